// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block sits on a simple 32-bit register bus and runs one successive-approximation conversion each time software asks for one. Software first programs a power-up wait, then writes the control word with a channel number and the power bit set. The block drives the channel select and power-enable lines of the analog front end and waits the programmed number of clocks. It then searches the code space one bit per clock, most significant bit first, against a single comparator input. At the end it stores the code and raises its interrupt flag.

Writing an all-zero control word acknowledges the interrupt and switches the front end off. If a conversion is still running, that write also abandons it. The multiplexer, DAC and comparator stay outside the block. One clock drives both the bus and the converter.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low, `adcPowerOn` is low and `chanSel` is zero.
- R2: Registers sit at byte offsets 0x0 (result), 0x4 (status), 0x8 (control) and 0xC (power-up wait). The wait register keeps only its low 6 bits, so writing 0xFF reads back 0x3F.
- R3: A nonzero control write with bit 3 set, made while idle, starts a conversion. Status bit 0 is high from that write until the result is stored. The flag sets exactly `wait + RES_BITS + 1` clock edges after the write edge.
- R4: The search resolves one bit per clock, MSB first. On `dacCode` it presents the kept bits plus the current trial bit. It keeps the trial bit when `cmpIn` is high, so the stored code is the largest code not above the modelled input.
- R5: Result register bits [RES_BITS-1:0] hold the code and the upper bits read zero. The value changes only when a conversion completes.
- R6: Control bit 6 (interrupt flag) sets when the last bit resolves. Bit 5 is the interrupt enable. `irq` is high exactly when both are set.
- R7: A control write of all zeros clears the flag and clears bits 3 and 5. It drops `adcPowerOn` and ends any conversion in progress, leaving the result register unchanged.
- R8: While busy, any nonzero control write is ignored. The running conversion keeps its channel and enable and completes normally.
- R9: Control bits [2:0] drive `chanSel` and bit 3 drives `adcPowerOn`. An accepted idle write also clears the flag.
- R10: A wait value of 0 gives a flag after `RES_BITS + 1` edges. A wait value of 63 gives one after `RES_BITS + 64` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and converter clock |
| rstN | input | 1 | Active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 4 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (zero when not selected) |
| cmpIn | input | 1 | Comparator: input at or above `dacCode` |
| dacCode | output | RES_BITS | Trial code for the DAC |
| chanSel | output | CHAN_BITS | Input channel select |
| adcPowerOn | output | 1 | Converter power enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 10-bit resolution, a 3-bit channel field and a 6-bit wait. The comparator model therefore covers all eight channels and the full 0 to 1023 input range, including both end codes. With a 6-bit wait, random and directed runs reach both extremes of the wait, 0 and 63. Each run's completion latency is counted edge by edge against the formula in R3. The bench also hits mid-search abort and ignored busy writes at fixed points in the search.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  localparam logic [3:0] ADDR_RESULT = 4'h0;
  localparam logic [3:0] ADDR_STATUS = 4'h4;
  localparam logic [3:0] ADDR_CTRL   = 4'h8;
  localparam logic [3:0] ADDR_WAIT   = 4'hC;

  localparam int CTRL_POWER_BIT = 3;
  localparam int CTRL_IEN_BIT   = 5;
  localparam int CTRL_FLAG_BIT  = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2
  } seqState_t;

  typedef struct packed {
    logic start;   // load MSB trial, clear kept bits
    logic step;    // resolve current trial bit
    logic clrFlag; // clear interrupt flag
  } sarStrobe_t;

endpackage

// File: rtl/sar_seq_ctl.sv
module sar_seq_ctl
  import sar_seq_pkg::*;
#(
  parameter int CHAN_BITS = 3,
  parameter int WAIT_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [3:0]           addr,
  input  logic [31:0]          wdata,
  input  logic                 lastBit,
  output sarStrobe_t           strb,
  output logic                 busy,
  output logic [CHAN_BITS-1:0] chanSel,
  output logic                 powerOn,
  output logic                 irqEn,
  output logic [WAIT_BITS-1:0] waitVal
);

  seqState_t            state;
  logic [WAIT_BITS-1:0] waitCnt;
  logic                 wrCtl, wrWait, ctlZero, abortReq, acceptReq;

  assign wrCtl     = wrEn && (addr == ADDR_CTRL);
  assign wrWait    = wrEn && (addr == ADDR_WAIT);
  assign ctlZero   = (wdata == 32'd0);
  assign abortReq  = wrCtl && ctlZero;
  assign acceptReq = wrCtl && !ctlZero && (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strb.start   = (state == ST_WAIT) && (waitCnt == '0) && !abortReq;
    strb.step    = (state == ST_CONV) && !abortReq;
    strb.clrFlag = abortReq || acceptReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      chanSel <= '0;
      powerOn <= 1'b0;
      irqEn   <= 1'b0;
      waitVal <= '0;
    end else begin
      if (wrWait) waitVal <= wdata[WAIT_BITS-1:0];
      if (abortReq) begin
        state   <= ST_IDLE;
        chanSel <= '0;
        powerOn <= 1'b0;
        irqEn   <= 1'b0;
      end else if (acceptReq) begin
        chanSel <= wdata[CHAN_BITS-1:0];
        powerOn <= wdata[CTRL_POWER_BIT];
        irqEn   <= wdata[CTRL_IEN_BIT];
        if (wdata[CTRL_POWER_BIT]) begin
          state   <= ST_WAIT;
          waitCnt <= waitVal;
        end
      end else begin
        case (state)
          ST_WAIT: begin
            if (waitCnt == '0) state <= ST_CONV;
            else               waitCnt <= waitCnt - 1'b1;
          end
          ST_CONV: if (lastBit) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7: an all-zero control write leaves the sequencer idle and unpowered
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (state == ST_IDLE) && !powerOn);

  // R8: nonzero control writes while busy do not disturb channel or enable
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && !ctlZero && busy) |=> $stable(chanSel) && $stable(irqEn));

  // R3: the wait phase persists while its count is nonzero
  p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && waitCnt != '0 && !abortReq) |=> (state == ST_WAIT));

endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobe_t          strb,
  input  logic                cmpIn,
  output logic [RES_BITS-1:0] dacCode,
  output logic                lastBit,
  output logic [RES_BITS-1:0] result,
  output logic                flag
);

  localparam logic [RES_BITS-1:0] MSB_MASK = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] kept;
  logic [RES_BITS-1:0] trialMask;
  logic [RES_BITS-1:0] trial;
  logic [RES_BITS-1:0] decided;

  assign trial   = kept | trialMask;
  assign decided = cmpIn ? trial : kept;
  assign dacCode = trial;
  assign lastBit = trialMask[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kept      <= '0;
      trialMask <= '0;
      result    <= '0;
      flag      <= 1'b0;
    end else begin
      if (strb.start) begin
        kept      <= '0;
        trialMask <= MSB_MASK;
      end else if (strb.step) begin
        kept      <= decided;
        trialMask <= trialMask >> 1;
        if (trialMask[0]) begin
          result <= decided;
          flag   <= 1'b1;
        end
      end
      if (strb.clrFlag) flag <= 1'b0;
    end
  end

  // R4: at most one trial bit is live at a time
  p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trialMask));

  // R4: a resolve strobe always has a bit to resolve
  p_step_has_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (trialMask != '0));

  // R5: the result only moves on the final resolve
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.step && trialMask[0]) |=> $stable(result));

  // R6: the flag only rises after the last bit resolves
  p_flag_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(strb.step && trialMask[0]));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int CHAN_BITS = 3,
  parameter int WAIT_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [3:0]           paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  input  logic                 cmpIn,
  output logic [RES_BITS-1:0]  dacCode,
  output logic [CHAN_BITS-1:0] chanSel,
  output logic                 adcPowerOn,
  output logic                 irq
);

  sarStrobe_t           strb;
  logic                 busy, irqEn, flag, lastBit;
  logic [RES_BITS-1:0]  result;
  logic [WAIT_BITS-1:0] waitVal;
  logic [31:0]          ctlWord;

  sar_seq_ctl #(.CHAN_BITS(CHAN_BITS), .WAIT_BITS(WAIT_BITS)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (psel && penable && pwrite),
    .addr    (paddr),
    .wdata   (pwdata),
    .lastBit (lastBit),
    .strb    (strb),
    .busy    (busy),
    .chanSel (chanSel),
    .powerOn (adcPowerOn),
    .irqEn   (irqEn),
    .waitVal (waitVal)
  );

  sar_seq_dp #(.RES_BITS(RES_BITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmpIn   (cmpIn),
    .dacCode (dacCode),
    .lastBit (lastBit),
    .result  (result),
    .flag    (flag)
  );

  always_comb begin
    ctlWord                  = '0;
    ctlWord[CHAN_BITS-1:0]   = chanSel;
    ctlWord[CTRL_POWER_BIT]  = adcPowerOn;
    ctlWord[CTRL_IEN_BIT]    = irqEn;
    ctlWord[CTRL_FLAG_BIT]   = flag;
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (paddr)
        ADDR_RESULT: prdata = {{(32-RES_BITS){1'b0}}, result};
        ADDR_STATUS: prdata = {31'd0, busy};
        ADDR_CTRL:   prdata = ctlWord;
        ADDR_WAIT:   prdata = {{(32-WAIT_BITS){1'b0}}, waitVal};
        default:     prdata = '0;
      endcase
    end
  end

  assign irq = flag && irqEn;

  // R1: nothing is powered or requesting in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rstN) |-> !irq && !adcPowerOn);

endmodule

// File: tb/sar_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sar_seq_ctrl_bench;

  localparam int RES = 10;
  localparam int CHB = 3;
  localparam int WB  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        cmpIn;
  logic [RES-1:0] dacCode;
  logic [CHB-1:0] chanSel;
  logic adcPowerOn, irq;

  logic [RES-1:0] vin [8];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign cmpIn = (vin[chanSel] >= dacCode);

  sar_seq_ctrl #(.RES_BITS(RES), .CHAN_BITS(CHB), .WAIT_BITS(WB)) u_sar_seq_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cmpIn(cmpIn),
    .dacCode(dacCode), .chanSel(chanSel), .adcPowerOn(adcPowerOn), .irq(irq)
  );

  function automatic logic [RES-1:0] sarModel(input logic [RES-1:0] v);
    logic [RES-1:0] code = '0;
    for (int b = RES - 1; b >= 0; b--) begin
      logic [RES-1:0] t = code | (RES'(1) << b);
      if (v >= t) code = t;
    end
    return code;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pwdata = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // starts with interrupt enabled, counts edges from the write edge to irq
  task automatic convMeasure(input int ch, input int wt, output int lat);
    busWrite(4'hC, 32'(wt));
    busWrite(4'h8, 32'h28 | 32'(ch));
    lat = 0;
    while (!irq && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] prevRes;
    int lat;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) vin[i] = RES'(i * 97 + 5);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    busRead(4'h0, rd); check("R1 result", rd, 0);
    busRead(4'h4, rd); check("R1 status", rd, 0);
    busRead(4'h8, rd); check("R1 control", rd, 0);
    busRead(4'hC, rd); check("R1 wait", rd, 0);
    check("R1 pins", {29'd0, irq, adcPowerOn, |chanSel}, 0);

    // R2: wait register width
    busWrite(4'hC, 32'hFF);
    busRead(4'hC, rd); check("R2 wait mask", rd, 32'h3F);

    // R3/R4/R6: directed conversion on channel 2 with wait 8
    vin[2] = 10'd613;
    convMeasure(2, 8, lat);
    check("R3 latency wait8", 32'(lat), 32'(8 + RES + 1));
    busRead(4'h0, rd); check("R4 result ch2", rd, 32'(sarModel(vin[2])));
    busRead(4'h8, rd); check("R6 flag+enable", rd, 32'h6A);
    check("R6 irq high", {31'd0, irq}, 1);
    check("R9 chanSel/power", {28'd0, adcPowerOn, chanSel}, {28'd0, 1'b1, 3'd2});

    // R3: busy visible during the run, clear after
    busWrite(4'hC, 32'd8);
    busWrite(4'h8, 32'h2B);
    busRead(4'h4, rd); check("R3 busy during", rd, 1);
    busRead(4'h8, rd); check("R9 start clears flag", rd & 32'h40, 0);
    while (!irq) @(negedge clk);
    busRead(4'h4, rd); check("R3 busy after", rd, 0);

    // R6: enable off, flag sets, irq stays low
    vin[4] = 10'd300;
    busWrite(4'hC, 32'd3);
    busWrite(4'h8, 32'h0C);
    repeat (3 + RES + 4) @(negedge clk);
    check("R6 irq masked", {31'd0, irq}, 0);
    busRead(4'h8, rd); check("R6 flag without enable", rd, 32'h4C);
    busRead(4'h0, rd); check("R4 result ch4", rd, 32'(sarModel(vin[4])));

    // R7: abort mid-search, result untouched
    prevRes = rd;
    vin[6] = 10'd900;
    busWrite(4'hC, 32'd8);
    busWrite(4'h8, 32'h2E);
    repeat (12) @(negedge clk);
    busWrite(4'h8, 32'd0);
    check("R7 power off", {30'd0, adcPowerOn, irq}, 0);
    busRead(4'h4, rd); check("R7 not busy", rd, 0);
    repeat (30) @(negedge clk);
    check("R7 no irq later", {31'd0, irq}, 0);
    busRead(4'h8, rd); check("R7 control cleared", rd, 0);
    busRead(4'h0, rd); check("R5 result held over abort", rd, prevRes);

    // R8: busy write to another channel ignored
    vin[1] = 10'd77; vin[5] = 10'd1000;
    busWrite(4'hC, 32'd4);
    busWrite(4'h8, 32'h29);
    busWrite(4'h8, 32'h2D);
    check("R8 chanSel kept", {29'd0, chanSel}, 1);
    while (!irq) @(negedge clk);
    busRead(4'h8, rd); check("R8 control kept", rd, 32'h69);
    busRead(4'h0, rd); check("R8 result from ch1", rd, 32'(sarModel(vin[1])));

    // R7: zero write acknowledges a finished conversion
    busWrite(4'h8, 32'd0);
    check("R7 irq cleared", {31'd0, irq}, 0);

    // R10: wait extremes
    convMeasure(3, 0, lat);
    check("R10 latency wait0", 32'(lat), 32'(RES + 1));
    convMeasure(3, 63, lat);
    check("R10 latency wait63", 32'(lat), 32'(63 + RES + 1));

    // R4/R5: end codes, full-word zero extension
    vin[0] = '0;
    convMeasure(0, 2, lat);
    busRead(4'h0, rd); check("R4 code zero", rd, 0);
    vin[7] = '1;
    convMeasure(7, 2, lat);
    busRead(4'h0, rd); check("R5 full scale zero-extended", rd, 32'h3FF);

    // R3/R4: random runs
    for (int n = 0; n < 24; n++) begin
      int ch = int'($urandom_range(0, 7));
      int wt = int'($urandom_range(0, 63));
      vin[ch] = RES'($urandom);
      convMeasure(ch, wt, lat);
      check("R3 random latency", 32'(lat), 32'(wt + RES + 1));
      busRead(4'h0, rd); check("R4 random result", rd, 32'(sarModel(vin[ch])));
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule